// File: doc/BRIEF.md
# Post-Trigger Bus Trace Recorder

This block keeps a rolling record of a target bus, one wide word per bus cycle, in a circular buffer. The words come from the pin state taken before any fault is applied, so the record shows what the bus should have carried. While the recorder is running, every bus-cycle strobe stores the current sample and advances the write address.

When a fault injection begins, the recorder latches the address of the entry that receives the first post-injection sample. It keeps recording until a fixed number of further samples has been written, and then freezes. With the default settings that number equals the buffer depth, so the whole buffer is refilled after the injection. A smaller post-trigger length keeps part of the pre-injection history in the buffer.

Once frozen, the buffer can be read by a host, one entry at a time. A re-arm pulse restarts free-running capture. As an option, the low eight bits of every stored word carry a wrapping count of bus cycles in place of sample bits, so that entries can be ordered in time.

Top module: `trace_capture`

## Requirements
- R1: After reset, `frozen` is 0, `trig_addr` is 0, `rd_data` is 0 and the cycle stamp is 0.
- R2: Each strobe on `smp_valid` while the recorder is not frozen writes one word at the current write address. The address then advances by one and wraps modulo DEPTH (default 4096 entries of DATA_W = 96 bits).
- R3: Bits [DATA_W-1:8] of a stored word equal `smp_data` unchanged. With the stamp enabled, bits [7:0] hold an 8-bit count of strobes. The count wraps at 256, starts at 0 after reset or re-arm, and advances on every strobe, including strobes seen while frozen.
- R4: An `inj_start` pulse while the recorder is running latches the current write address into `trig_addr`, one cycle later. That entry receives the first post-trigger sample.
- R5: After a trigger, exactly POST_LEN samples are written, counting a sample accepted in the trigger cycle. `frozen` rises in the cycle after the last of these writes. POST_LEN defaults to DEPTH.
- R6: While frozen, strobes write nothing and the write address holds.
- R7: An `inj_start` pulse during the post-trigger fill is ignored. `trig_addr` and the freeze point are unchanged.
- R8: When `rd_en` is high while frozen, `rd_data` shows the entry at `rd_addr` one cycle later. At any other time, `rd_data` holds its value.
- R9: `rearm` drops `frozen` in the next cycle, resumes running capture and clears the stamp. It takes precedence over an `inj_start` in the same cycle, which is then ignored. The write address is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Bus-cycle strobe, one sample per pulse |
| smp_data | input | DATA_W | Fault-free pin state |
| inj_start | input | 1 | Pulse marking the start of a fault injection |
| rearm | input | 1 | Restart free-running capture |
| rd_en | input | 1 | Host read request |
| rd_addr | input | $clog2(DEPTH) | Host read address |
| rd_data | output | DATA_W | Host read word, registered |
| trig_addr | output | $clog2(DEPTH) | Entry holding the first post-trigger sample |
| frozen | output | 1 | Capture complete, buffer readable |

## Verification
The three result paths each take one register stage:
- `trig_addr` changes one cycle after the `inj_start` pulse.
- `frozen` changes one cycle after the final post-trigger write, or one cycle after `rearm`.
- `rd_data` changes one cycle after a frozen read request.

The bench drives inputs on the falling edge and samples outputs on the next falling edge. Each result is therefore checked exactly one rising edge after its cause. The freeze point is bracketed by checking `frozen` low after POST_LEN-1 post-trigger samples and high after the last one. Buffer contents are compared entry by entry after freezing, including the wrapped pre-trigger entries.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;
   typedef enum logic [1:0] {
      CAP_RUN  = 2'd0,
      CAP_POST = 2'd1,
      CAP_HOLD = 2'd2
   } cap_state_e;
endpackage

// File: rtl/trace_cap_ctrl.sv
module trace_cap_ctrl
   import trace_cap_pkg::*;
#(
   parameter int DEPTH    = 4096,
   parameter int POST_LEN = DEPTH,
   localparam int AW      = $clog2(DEPTH),
   localparam int CW      = $clog2(POST_LEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_valid,
   input  logic          inj_start,
   input  logic          rearm,
   output logic          wr_en,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] trig_addr,
   output logic          frozen,
   output logic          post_busy
);
   cap_state_e    state_q;
   logic [CW-1:0] post_cnt;
   logic [CW-1:0] cnt_base;
   logic [CW-1:0] cnt_next;
   logic          trig_hit;
   logic          last_wr;

   always_comb begin
      wr_en    = smp_valid && (state_q != CAP_HOLD);
      trig_hit = (state_q == CAP_RUN) && inj_start && !rearm;
      cnt_base = trig_hit ? '0 : post_cnt;
      cnt_next = cnt_base + (wr_en ? CW'(1) : CW'(0));
      last_wr  = (trig_hit || state_q == CAP_POST) && wr_en
                 && (cnt_base == CW'(POST_LEN - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= CAP_RUN;
         post_cnt  <= '0;
         trig_addr <= '0;
      end else if (rearm) begin
         state_q  <= CAP_RUN;
         post_cnt <= '0;
      end else begin
         unique case (state_q)
            CAP_RUN: if (trig_hit) begin
               trig_addr <= wr_ptr;
               post_cnt  <= cnt_next;
               state_q   <= last_wr ? CAP_HOLD : CAP_POST;
            end
            CAP_POST: begin
               post_cnt <= cnt_next;
               if (last_wr) state_q <= CAP_HOLD;
            end
            default: state_q <= CAP_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     wr_ptr <= '0;
      else if (wr_en) wr_ptr <= wr_ptr + AW'(1);
   end

   assign frozen    = (state_q == CAP_HOLD);
   assign post_busy = (state_q == CAP_POST);
endmodule

// File: rtl/trace_cap_stamp.sv
module trace_cap_stamp #(
   parameter int STAMP_W  = 8,
   parameter bit STAMP_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               clear,
   output logic [STAMP_W-1:0] stamp
);
   generate
      if (STAMP_EN) begin : g_count
         always_ff @(posedge clk) begin
            if (!rst_n || clear) stamp <= '0;
            else if (tick)       stamp <= stamp + STAMP_W'(1);
         end
      end else begin : g_none
         logic unused_in;
         assign unused_in = ^{clk, rst_n, tick, clear};
         assign stamp     = '0;
      end
   endgenerate
endmodule

// File: rtl/trace_cap_mem.sv
module trace_cap_mem #(
   parameter int W     = 96,
   parameter int DEPTH = 4096,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [W-1:0]  wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [W-1:0]  rd_data
);
   logic [W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= store[rd_addr];
   end
endmodule

// File: rtl/trace_capture.sv
module trace_capture #(
   parameter int DATA_W   = 96,
   parameter int DEPTH    = 4096,
   parameter int POST_LEN = DEPTH,
   parameter bit STAMP_EN = 1'b1,
   parameter int STAMP_W  = 8,
   localparam int AW      = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              inj_start,
   input  logic              rearm,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [AW-1:0]     trig_addr,
   output logic              frozen
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (POST_LEN < 1 || POST_LEN > DEPTH) begin : g_bad_post
         $error("POST_LEN must lie in 1..DEPTH");
      end
      if (STAMP_EN && STAMP_W >= DATA_W) begin : g_bad_stamp
         $error("STAMP_W must be narrower than DATA_W");
      end
   endgenerate

   logic              wr_en;
   logic [AW-1:0]     wr_ptr;
   logic              post_busy;
   logic [STAMP_W-1:0] stamp_val;
   logic [DATA_W-1:0] wr_word;

   trace_cap_ctrl #(.DEPTH(DEPTH), .POST_LEN(POST_LEN)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .inj_start (inj_start),
      .rearm     (rearm),
      .wr_en     (wr_en),
      .wr_ptr    (wr_ptr),
      .trig_addr (trig_addr),
      .frozen    (frozen),
      .post_busy (post_busy)
   );

   trace_cap_stamp #(.STAMP_W(STAMP_W), .STAMP_EN(STAMP_EN)) u_stamp (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (smp_valid),
      .clear (rearm),
      .stamp (stamp_val)
   );

   generate
      if (STAMP_EN) begin : g_word_stamp
         logic unused_lo;
         assign unused_lo = ^smp_data[STAMP_W-1:0];
         assign wr_word   = {smp_data[DATA_W-1:STAMP_W], stamp_val};
      end else begin : g_word_raw
         assign wr_word = smp_data;
      end
   endgenerate

   trace_cap_mem #(.W(DATA_W), .DEPTH(DEPTH)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_ptr),
      .wr_data (wr_word),
      .rd_en   (rd_en && frozen),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
   parameter int DATA_W   = 96,
   parameter int DEPTH    = 4096,
   parameter bit STAMP_EN = 1'b1,
   parameter int STAMP_W  = 8,
   localparam int AW      = $clog2(DEPTH)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               smp_valid,
   input logic               rearm,
   input logic               rd_en,
   input logic               frozen,
   input logic               post_busy,
   input logic               wr_en,
   input logic [AW-1:0]      wr_ptr,
   input logic [AW-1:0]      trig_addr,
   input logic [DATA_W-1:0]  rd_data,
   input logic [STAMP_W-1:0] stamp
);
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> wr_ptr == AW'($past(wr_ptr) + AW'(1)));                  // R2
   AST_FREEZE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frozen) |-> $past(wr_en));                                    // R5
   AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      frozen && !rearm |=> frozen && $stable(wr_ptr));                    // R6
   AST_TRIG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (post_busy || frozen) && !rearm |=> $stable(trig_addr));            // R7
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && frozen) |=> $stable(rd_data));                           // R8
   AST_REARM_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> !frozen && !post_busy);                                   // R9

   generate
      if (STAMP_EN) begin : g_stamp_chk
         AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            smp_valid && !rearm |=> stamp == STAMP_W'($past(stamp) + STAMP_W'(1))); // R3
      end
   endgenerate
endmodule

bind trace_capture trace_capture_chk #(
   .DATA_W(DATA_W), .DEPTH(DEPTH), .STAMP_EN(STAMP_EN), .STAMP_W(STAMP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_valid (smp_valid),
   .rearm     (rearm),
   .rd_en     (rd_en),
   .frozen    (frozen),
   .post_busy (post_busy),
   .wr_en     (wr_en),
   .wr_ptr    (wr_ptr),
   .trig_addr (trig_addr),
   .rd_data   (rd_data),
   .stamp     (stamp_val)
);

// File: tb/trace_capture_tb.sv
module trace_capture_tb;
   localparam int W  = 96;
   localparam int D  = 16;
   localparam int PL = 12;
   localparam int AW = $clog2(D);

   logic          clk = 1'b0;
   logic          rst_n, smp_valid, inj_start, rearm, rd_en;
   logic [W-1:0]  smp_data;
   logic [AW-1:0] rd_addr;
   logic [W-1:0]  rd_data;
   logic [AW-1:0] trig_addr;
   logic          frozen;

   always #4 clk = ~clk;

   trace_capture #(.DATA_W(W), .DEPTH(D), .POST_LEN(PL), .STAMP_EN(1'b1), .STAMP_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .inj_start(inj_start), .rearm(rearm), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .trig_addr(trig_addr), .frozen(frozen)
   );

   int n_chk = 0, n_bad = 0, seq = 0;
   logic [W-1:0] m_mem [D];
   int m_wp = 0, m_stamp = 0, m_cnt = 0, m_trig = 0;
   bit m_frz = 0, m_post = 0;

   function automatic logic [W-1:0] mk(int i);
      return {32'hA5A5_0F0F ^ 32'(i), 32'hDEAD_0000 + 32'(i), 32'(i * 37 + 11)};
   endfunction

   task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // one input cycle; the model follows the requirements
   task automatic cyc(bit v, bit inj, bit ra);
      logic [W-1:0] d;
      d = mk(seq);
      @(negedge clk);
      smp_valid = v; inj_start = inj; rearm = ra; smp_data = d; rd_en = 1'b0;
      if (ra) begin
         m_frz = 0; m_post = 0; m_stamp = 0;
      end else begin
         if (inj && !m_post && !m_frz) begin m_trig = m_wp; m_post = 1; m_cnt = 0; end
         if (v && !m_frz) begin
            m_mem[m_wp] = {d[W-1:8], 8'(m_stamp)};
            m_wp = (m_wp + 1) % D;
            if (m_post) begin
               m_cnt++;
               if (m_cnt == PL) begin m_frz = 1; m_post = 0; end
            end
         end
         if (v) m_stamp = (m_stamp + 1) % 256;
      end
      seq++;
   endtask

   task automatic rd_chk(int a, string req);
      @(negedge clk);
      smp_valid = 0; inj_start = 0; rearm = 0; rd_en = 1'b1; rd_addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      chk(req, $sformatf("entry %0d", a), rd_data, m_mem[a]);
   endtask

   task automatic t_reset;
      chk("R1", "frozen", W'(frozen), '0);
      chk("R1", "trig_addr", W'(trig_addr), '0);
      chk("R1", "rd_data", rd_data, '0);
   endtask

   task automatic t_run_wrap;
      for (int i = 0; i < 20; i++) cyc(1, 0, 0);
      cyc(0, 0, 0);
      chk("R2", "frozen while running", W'(frozen), '0);
      @(negedge clk); rd_en = 1'b1; rd_addr = '0;
      @(negedge clk); rd_en = 1'b0;
      chk("R8", "rd_data held when not frozen", rd_data, '0);
   endtask

   task automatic t_trigger;
      cyc(1, 1, 0);
      cyc(0, 0, 0);
      chk("R4", "trig_addr", W'(trig_addr), W'(m_trig));
      chk("R4", "trig_addr value", W'(trig_addr), W'(4));
      for (int i = 0; i < 4; i++) cyc(1, 0, 0);
      cyc(1, 1, 0);
      for (int i = 0; i < PL - 7; i++) cyc(1, 0, 0);
      cyc(0, 0, 0);
      chk("R7", "trig_addr after second pulse", W'(trig_addr), W'(4));
      chk("R5", "frozen before last sample", W'(frozen), '0);
      cyc(1, 0, 0);
      cyc(0, 0, 0);
      chk("R5", "frozen after last sample", W'(frozen), W'(1));
      for (int i = 0; i < 3; i++) cyc(1, 0, 0);
      cyc(0, 0, 0);
      chk("R6", "frozen stays", W'(frozen), W'(1));
      for (int a = 0; a < D; a++) rd_chk(a, (a < 4) ? "R2" : "R3");
   endtask

   task automatic t_rearm;
      cyc(0, 1, 1);
      cyc(0, 0, 0);
      chk("R9", "frozen after rearm", W'(frozen), '0);
      chk("R9", "trig_addr unchanged", W'(trig_addr), W'(4));
      for (int i = 0; i < PL; i++) cyc(1, 0, 0);
      cyc(0, 0, 0);
      chk("R9", "trigger with rearm ignored", W'(frozen), '0);
      cyc(0, 1, 0);
      cyc(0, 0, 0);
      chk("R4", "trig_addr idle trigger", W'(trig_addr), W'(12));
      for (int i = 0; i < PL; i++) cyc(1, 0, 0);
      cyc(0, 0, 0);
      chk("R5", "frozen after refill", W'(frozen), W'(1));
      for (int a = 0; a < D; a++) rd_chk(a, "R3");
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 0; smp_valid = 0; inj_start = 0; rearm = 0; rd_en = 0;
      smp_data = '0; rd_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_run_wrap();
      t_trigger();
      t_rearm();
      finish_run();
   end
endmodule